// File: doc/BRIEF.md
# Byte-Port Packet Network Interface

This block puts a simple network interface on a processor bus. To send, software writes a frame length and then writes the frame one byte at a time into a data port. When the number of bytes written reaches the programmed length, the block sends the whole frame on a byte stream output without further command and raises a transmit-done flag.

An arriving packet is stored whole in a receive buffer, starting at index 0. Software learns of it from a receive-done flag and the receive count. It then reads the packet out byte by byte through a read port.

The register file holds:
- a two-word identification constant;
- a busy flag;
- the receive and transmit counts;
- an interrupt control register with a software test flag;
- a constant interrupt-info word.

A level interrupt output is high while any interrupt flag is set. Bus reads return their data one cycle after the read strobe. The side effects of a read take effect at the same edge that captures the data.

Top module: `pkt_bus_nic`

## Requirements
- R1: After reset, all counts, indices and interrupt flags are zero, `irq_o` and `pkt_valid_o` are low, and reads of the busy (0x08), receive count (0x0C), transmit count (0x10) and interrupt control (0x14) registers return 0.
- R2: A read at byte offset 0x00 returns 32'h4D495053 and a read at 0x04 returns 32'h4E455430. Read data appears on `bus_rdata_o` in the cycle after `bus_rd_i`.
- R3: A write to 0x10 stores the value if it is at most DEPTH (1514), and stores 0 otherwise. A read of 0x10 returns the stored value.
- R4: Each write to 0x20 stores `bus_wdata_i[7:0]` at the transmit write index and advances that index. The write that makes the index equal to the programmed count does three things: it clears both the count and the index; it sends exactly that many bytes on `pkt_data_o`, in the order they were written, with `pkt_valid_o` high on consecutive cycles; and it marks the final byte with `pkt_last_o`.
- R5: Sending a frame sets the transmit-done flag, which is bit 0 of 0x14.
- R6: A write to 0x14 is handled by priority. If bit 0 is set, only transmit-done is cleared. Otherwise, if bit 1 is set, only receive-done (bit 1) is cleared. Otherwise, if bit 31 is set, the test flag (bit 31) is set.
- R7: A read of 0x14 returns the flags as they were, then clears the test flag.
- R8: `irq_o` and bit 0 of the busy register are both high exactly while any of the three flags is set.
- R9: A packet on `rx_valid_i`/`rx_data_i`, ending with the byte flagged `rx_last_i`, is accepted only if the receive count is below DEPTH when its first byte arrives. An accepted packet is stored from index 0, loads the receive count with its length, resets the read index and sets receive-done. A packet that is refused leaves the count and the buffer unchanged.
- R10: Each read of 0x1C returns the next received byte in `bus_rdata_o[7:0]`, advances the read index and decrements the receive count. While the count is 0, a read returns 0 and changes nothing.
- R11: Writes to 0x00, 0x04, 0x08, 0x0C, 0x18 and 0x1C have no effect.
- R12: If a packet completes in the same cycle as a write to 0x14 that would clear receive-done, the flag ends set.
- R13: A read of 0x18 returns the IRQ_INFO parameter (default 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 6 | Byte offset of the register |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, one cycle after the strobe |
| rx_valid_i | input | 1 | Inbound byte valid |
| rx_last_i | input | 1 | Inbound byte is the last of its packet |
| rx_data_i | input | 8 | Inbound byte |
| pkt_valid_o | output | 1 | Outbound byte valid |
| pkt_last_o | output | 1 | Outbound byte ends the frame |
| pkt_data_o | output | 8 | Outbound byte |
| irq_o | output | 1 | Level interrupt |

## Verification
Two things can land on the same clock edge: the completion of an inbound packet, and a software write to interrupt control that clears receive-done. The bench raises the last inbound byte and that write at the same falling edge, then reads interrupt control and expects bit 1 to be set. The bench also checks that a completed packet reloads the receive count even while the read port was being drained in the cycles before.

// File: rtl/nic_pkg.sv
package nic_pkg;
  localparam int unsigned ADDR_W = 6;
  localparam logic [ADDR_W-1:0] OFS_ID0   = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_ID1   = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_BUSY  = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_RXCNT = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_TXCNT = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_ICTL  = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_INFO  = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_RXDAT = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_TXDAT = 6'h20;
  typedef enum logic [1:0] {RX_IDLE, RX_CAP, RX_DROP} rx_state_e;
endpackage

// File: rtl/nic_tx_path.sv
module nic_tx_path #(
  parameter int unsigned DEPTH = 1514,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_we_i,
  input  logic [31:0]      cnt_wdata_i,
  input  logic             dat_we_i,
  input  logic [7:0]       dat_i,
  output logic [CNT_W-1:0] tx_cnt_o,
  output logic             done_o,
  output logic             pkt_valid_o,
  output logic             pkt_last_o,
  output logic [7:0]       pkt_data_o
);
  localparam int unsigned IDX_W = $clog2(DEPTH);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(DEPTH);

  logic [7:0]       mem [DEPTH];
  logic [CNT_W-1:0] tx_cnt_q, wr_idx_q, rd_ptr_q, len_q;
  logic             active_q, fire, room;

  assign room   = wr_idx_q < LIM;
  assign fire   = dat_we_i && room && (wr_idx_q + CNT_W'(1) == tx_cnt_q);
  assign done_o = fire;
  assign tx_cnt_o = tx_cnt_q;

  always_ff @(posedge clk_i) begin
    if (dat_we_i && room) mem[wr_idx_q[IDX_W-1:0]] <= dat_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_cnt_q <= '0;
      wr_idx_q <= '0;
    end else if (cnt_we_i) begin
      tx_cnt_q <= (cnt_wdata_i <= 32'(DEPTH)) ? cnt_wdata_i[CNT_W-1:0] : '0;
    end else if (fire) begin
      tx_cnt_q <= '0;
      wr_idx_q <= '0;
    end else if (dat_we_i && room) begin
      wr_idx_q <= wr_idx_q + CNT_W'(1);
    end
  end

  // frame streamer: reads the buffer after the completing write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q    <= 1'b0;
      rd_ptr_q    <= '0;
      len_q       <= '0;
      pkt_valid_o <= 1'b0;
      pkt_last_o  <= 1'b0;
      pkt_data_o  <= '0;
    end else begin
      pkt_valid_o <= active_q;
      pkt_last_o  <= active_q && (rd_ptr_q == len_q - CNT_W'(1));
      pkt_data_o  <= active_q ? mem[rd_ptr_q[IDX_W-1:0]] : 8'h00;
      if (fire) begin
        active_q <= 1'b1;
        rd_ptr_q <= '0;
        len_q    <= tx_cnt_q;
      end else if (active_q) begin
        rd_ptr_q <= rd_ptr_q + CNT_W'(1);
        if (rd_ptr_q == len_q - CNT_W'(1)) active_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/nic_rx_path.sv
module nic_rx_path
  import nic_pkg::*;
#(
  parameter int unsigned DEPTH = 1514,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic             in_last_i,
  input  logic [7:0]       in_data_i,
  input  logic             pop_i,
  output logic [CNT_W-1:0] rx_cnt_o,
  output logic [7:0]       rd_byte_o,
  output logic             done_o
);
  localparam int unsigned IDX_W = $clog2(DEPTH);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(DEPTH);

  logic [7:0]       mem [DEPTH];
  rx_state_e        st_q;
  logic [CNT_W-1:0] cap_idx_q, cur_idx, rx_cnt_q, rd_idx_q, len;
  logic             accept, taking, wr_en, end_pkt;

  assign accept  = in_valid_i && (st_q == RX_IDLE) && (rx_cnt_q < LIM);
  assign taking  = accept || (in_valid_i && st_q == RX_CAP);
  assign cur_idx = accept ? '0 : cap_idx_q;
  assign wr_en   = taking && (cur_idx < LIM);
  assign end_pkt = taking && in_last_i;
  assign len     = (cur_idx < LIM) ? cur_idx + CNT_W'(1) : LIM;
  assign done_o  = end_pkt;
  assign rx_cnt_o  = rx_cnt_q;
  assign rd_byte_o = (rx_cnt_q != '0) ? mem[rd_idx_q[IDX_W-1:0]] : 8'h00;

  always_ff @(posedge clk_i) begin
    if (wr_en) mem[cur_idx[IDX_W-1:0]] <= in_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= RX_IDLE;
      cap_idx_q <= '0;
    end else if (in_valid_i) begin
      unique case (st_q)
        RX_IDLE: begin
          if (!in_last_i) st_q <= accept ? RX_CAP : RX_DROP;
          cap_idx_q <= CNT_W'(1);
        end
        RX_CAP: begin
          if (in_last_i) st_q <= RX_IDLE;
          else if (cap_idx_q < LIM) cap_idx_q <= cap_idx_q + CNT_W'(1);
        end
        default: if (in_last_i) st_q <= RX_IDLE;
      endcase
    end
  end

  // completion reload wins over a concurrent pop
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_cnt_q <= '0;
      rd_idx_q <= '0;
    end else if (end_pkt) begin
      rx_cnt_q <= len;
      rd_idx_q <= '0;
    end else if (pop_i && rx_cnt_q != '0) begin
      rx_cnt_q <= rx_cnt_q - CNT_W'(1);
      rd_idx_q <= rd_idx_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/nic_irq_ctl.sv
module nic_irq_ctl (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [2:0] ack_i,   // {test, rx, tx} bits of the write
  input  logic       re_i,
  input  logic       tx_evt_i,
  input  logic       rx_evt_i,
  output logic [2:0] flags_o, // {test, rx, tx}
  output logic       irq_o
);
  logic tx_q, rx_q, test_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q   <= 1'b0;
      rx_q   <= 1'b0;
      test_q <= 1'b0;
    end else begin
      if (tx_evt_i)               tx_q <= 1'b1;
      else if (we_i && ack_i[0])  tx_q <= 1'b0;
      if (rx_evt_i)                          rx_q <= 1'b1;
      else if (we_i && !ack_i[0] && ack_i[1]) rx_q <= 1'b0;
      if (we_i && ack_i == 3'b100) test_q <= 1'b1;
      else if (re_i)               test_q <= 1'b0;
    end
  end

  assign flags_o = {test_q, rx_q, tx_q};
  assign irq_o   = tx_q | rx_q | test_q;
endmodule

// File: rtl/pkt_bus_nic.sv
module pkt_bus_nic
  import nic_pkg::*;
#(
  parameter int unsigned DEPTH    = 1514,
  parameter logic [31:0] ID_WORD0 = 32'h4D495053,
  parameter logic [31:0] ID_WORD1 = 32'h4E455430,
  parameter logic [31:0] IRQ_INFO = 32'h0000_0002
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic              rx_valid_i,
  input  logic              rx_last_i,
  input  logic [7:0]        rx_data_i,
  output logic              pkt_valid_o,
  output logic              pkt_last_o,
  output logic [7:0]        pkt_data_o,
  output logic              irq_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] tx_cnt, rx_cnt;
  logic [7:0]       rx_byte;
  logic [2:0]       flags;
  logic             tx_evt, rx_evt;
  logic [31:0]      rd_mux;

  nic_tx_path #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_tx (
    .clk_i, .rst_ni,
    .cnt_we_i   (bus_wr_i && bus_addr_i == OFS_TXCNT),
    .cnt_wdata_i(bus_wdata_i),
    .dat_we_i   (bus_wr_i && bus_addr_i == OFS_TXDAT),
    .dat_i      (bus_wdata_i[7:0]),
    .tx_cnt_o   (tx_cnt),
    .done_o     (tx_evt),
    .pkt_valid_o, .pkt_last_o, .pkt_data_o
  );

  nic_rx_path #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_rx (
    .clk_i, .rst_ni,
    .in_valid_i(rx_valid_i),
    .in_last_i (rx_last_i),
    .in_data_i (rx_data_i),
    .pop_i     (bus_rd_i && bus_addr_i == OFS_RXDAT),
    .rx_cnt_o  (rx_cnt),
    .rd_byte_o (rx_byte),
    .done_o    (rx_evt)
  );

  nic_irq_ctl u_irq (
    .clk_i, .rst_ni,
    .we_i    (bus_wr_i && bus_addr_i == OFS_ICTL),
    .ack_i   ({bus_wdata_i[31], bus_wdata_i[1], bus_wdata_i[0]}),
    .re_i    (bus_rd_i && bus_addr_i == OFS_ICTL),
    .tx_evt_i(tx_evt),
    .rx_evt_i(rx_evt),
    .flags_o (flags),
    .irq_o
  );

  always_comb begin
    unique case (bus_addr_i)
      OFS_ID0:   rd_mux = ID_WORD0;
      OFS_ID1:   rd_mux = ID_WORD1;
      OFS_BUSY:  rd_mux = {31'd0, irq_o};
      OFS_RXCNT: rd_mux = 32'(rx_cnt);
      OFS_TXCNT: rd_mux = 32'(tx_cnt);
      OFS_ICTL:  rd_mux = {flags[2], 29'd0, flags[1], flags[0]};
      OFS_INFO:  rd_mux = IRQ_INFO;
      OFS_RXDAT: rd_mux = {24'd0, rx_byte};
      default:   rd_mux = 32'd0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       bus_rdata_o <= '0;
    else if (bus_rd_i) bus_rdata_o <= rd_mux;
  end
endmodule

// File: rtl/nic_checker.sv
module nic_checker
  import nic_pkg::*;
#(
  parameter int unsigned DEPTH = 1514,
  parameter int unsigned CNT_W = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_wr_i,
  input logic              bus_rd_i,
  input logic [31:0]       bus_wdata_i,
  input logic              pkt_valid_o,
  input logic              pkt_last_o,
  input logic              irq_o,
  input logic [2:0]        flags_i,
  input logic [CNT_W-1:0]  tx_cnt_i,
  input logic [CNT_W-1:0]  rx_cnt_i,
  input logic              rx_evt_i
);
  assert_txcnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_cnt_i <= CNT_W'(DEPTH));

  assert_last_in_frame_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_last_o |-> pkt_valid_o);

  assert_tx_ack_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == OFS_ICTL && bus_wdata_i[0]) |=> !flags_i[0]);

  assert_rx_kept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == OFS_ICTL && bus_wdata_i[0] && !rx_evt_i)
      |=> flags_i[1] == $past(flags_i[1]));

  assert_test_rdclr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && !bus_wr_i && bus_addr_i == OFS_ICTL) |=> !flags_i[2]);

  assert_irq_on_rx_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_evt_i |=> irq_o);

  assert_empty_read_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && bus_addr_i == OFS_RXDAT && rx_cnt_i == '0 && !rx_evt_i)
      |=> rx_cnt_i == '0);

  assert_event_wins_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_evt_i |=> flags_i[1]);
endmodule

bind pkt_bus_nic nic_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_addr_i(bus_addr_i), .bus_wr_i(bus_wr_i),
  .bus_rd_i(bus_rd_i), .bus_wdata_i(bus_wdata_i), .pkt_valid_o(pkt_valid_o),
  .pkt_last_o(pkt_last_o), .irq_o(irq_o), .flags_i(flags), .tx_cnt_i(tx_cnt),
  .rx_cnt_i(rx_cnt), .rx_evt_i(rx_evt)
);

// File: tb/pkt_bus_nic_test.sv
module pkt_bus_nic_test;
  localparam int DEPTH = 1514;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [5:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic        rxv = 1'b0, rxl = 1'b0;
  logic [7:0]  rxd = '0;
  logic        pv, pl, irq;
  logic [7:0]  pd;

  int n_chk = 0, n_fail = 0, n_last = 0;
  logic [7:0] mon_q[$];
  logic [7:0] exp_q[$];
  logic [7:0] pat [0:1599];

  always #10 clk = ~clk;

  pkt_bus_nic uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .rx_valid_i(rxv), .rx_last_i(rxl),
    .rx_data_i(rxd), .pkt_valid_o(pv), .pkt_last_o(pl), .pkt_data_o(pd), .irq_o(irq)
  );

  always @(negedge clk) if (pv) begin
    mon_q.push_back(pd);
    if (pl) n_last++;
  end

  function automatic logic [31:0] ictl_word(input logic t, input logic r, input logic x);
    return {t, 29'd0, r, x};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_w(input logic [5:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_r(input logic [5:0] a, output logic [31:0] d);
    addr = a; rd = 1'b1;
    @(posedge clk); @(negedge clk);
    rd = 1'b0; d = rdata;
  endtask

  task automatic rx_send(input int len);
    for (int i = 0; i < len; i++) begin
      rxv = 1'b1; rxd = pat[i]; rxl = (i == len - 1);
      @(posedge clk); @(negedge clk);
    end
    rxv = 1'b0; rxl = 1'b0;
  endtask

  task automatic fill_pat(input int len);
    for (int i = 0; i < len; i++) pat[i] = 8'($urandom);
  endtask

  task automatic tx_frame(input int len);
    logic [31:0] v;
    int base;
    base = n_last;
    mon_q.delete(); exp_q.delete();
    bus_w(6'h10, len);
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      exp_q.push_back(b);
      bus_w(6'h20, {24'hABCDEF, b});
    end
    bus_r(6'h10, v);
    check("R4 count cleared", v, 0);
    repeat (len + 4) @(negedge clk);
    check("R4 frame length", mon_q.size(), len);
    check("R4 one last flag", n_last - base, 1);
    for (int i = 0; i < len && i < mon_q.size(); i++)
      if (mon_q[i] !== exp_q[i]) check("R4 frame byte", mon_q[i], exp_q[i]);
    bus_r(6'h14, v);
    check("R5 tx done set", v[0], 1);
    check("R8 irq with tx done", irq, 1);
    bus_w(6'h14, 32'h1);
    bus_r(6'h14, v);
    check("R6 tx done cleared", v[0], 0);
  endtask

  task automatic rx_drain(input int len);
    logic [31:0] v;
    bus_r(6'h0C, v);
    check("R9 rx count", v, len);
    for (int i = 0; i < len; i++) begin
      bus_r(6'h1C, v);
      if (v !== {24'd0, pat[i]}) check("R10 rx byte", v, {24'd0, pat[i]});
    end
    bus_r(6'h0C, v);
    check("R10 count drained", v, 0);
    bus_r(6'h1C, v);
    check("R10 empty read", v, 0);
    bus_r(6'h0C, v);
    check("R10 empty read no change", v, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", irq, 0);
    check("R1 pkt_valid", pv, 0);
    bus_r(6'h08, v); check("R1 busy", v, 0);
    bus_r(6'h0C, v); check("R1 rx count", v, 0);
    bus_r(6'h10, v); check("R1 tx count", v, 0);
    bus_r(6'h14, v); check("R1 ictl", v, 0);

    // R2 / R13 constants
    bus_r(6'h00, v); check("R2 id0", v, 32'h4D495053);
    bus_r(6'h04, v); check("R2 id1", v, 32'h4E455430);
    bus_r(6'h18, v); check("R13 info", v, 32'h2);

    // R3 length bounds
    bus_w(6'h10, DEPTH);     bus_r(6'h10, v); check("R3 max kept", v, DEPTH);
    bus_w(6'h10, DEPTH + 1); bus_r(6'h10, v); check("R3 over zeroed", v, 0);
    bus_w(6'h10, 32'h8000_0005); bus_r(6'h10, v); check("R3 huge zeroed", v, 0);

    // R4/R5 directed corners and random frames
    tx_frame(1);
    tx_frame(2);
    for (int k = 0; k < 5; k++) tx_frame(1 + int'($urandom_range(39)));

    // R9/R10 random packets
    for (int k = 0; k < 5; k++) begin
      int len;
      len = 1 + int'($urandom_range(39));
      fill_pat(len);
      rx_send(len);
      bus_r(6'h14, v); check("R9 rx done", v[1], 1);
      rx_drain(len);
      bus_w(6'h14, 32'h2);
    end

    // R6 priority with both flags set
    tx_frame(3); // leaves tx done clear; set it again below
    bus_w(6'h10, 1); bus_w(6'h20, 8'h55);
    repeat (4) @(negedge clk);
    fill_pat(4); rx_send(4);
    bus_r(6'h14, v); check("R6 both set", v, ictl_word(0, 1, 1));
    bus_w(6'h14, 32'h8000_0003);
    bus_r(6'h14, v); check("R6 bit0 wins", v, ictl_word(0, 1, 0));
    bus_w(6'h14, 32'h8000_0002);
    bus_r(6'h14, v); check("R6 bit1 next", v, ictl_word(0, 0, 0));
    check("R8 irq low", irq, 0);

    // R7 test flag
    bus_w(6'h14, 32'h8000_0000);
    check("R8 irq test", irq, 1);
    bus_r(6'h08, v); check("R8 busy test", v, 1);
    bus_r(6'h14, v); check("R7 read shows test", v, ictl_word(1, 0, 0));
    bus_r(6'h14, v); check("R7 cleared by read", v, 0);
    check("R8 irq after read", irq, 0);

    // R11 read-only writes ignored (4 bytes pending from last packet)
    bus_w(6'h00, 32'hFFFF_FFFF); bus_w(6'h04, 32'hFFFF_FFFF);
    bus_w(6'h08, 32'hFFFF_FFFF); bus_w(6'h0C, 32'h3);
    bus_w(6'h18, 32'hFFFF_FFFF); bus_w(6'h1C, 32'hFFFF_FFFF);
    bus_r(6'h00, v); check("R11 id0", v, 32'h4D495053);
    bus_r(6'h04, v); check("R11 id1", v, 32'h4E455430);
    bus_r(6'h08, v); check("R11 busy", v, 0);
    bus_r(6'h18, v); check("R11 info", v, 32'h2);
    bus_r(6'h0C, v); check("R11 rx count", v, 4);
    bus_r(6'h1C, v); check("R11 no pop", v, {24'd0, pat[0]});
    bus_r(6'h0C, v); check("R10 pop decrements", v, 3);

    // R9 full buffer refuses, then accepts after a read
    fill_pat(DEPTH);
    rx_send(DEPTH);
    bus_r(6'h0C, v); check("R9 full count", v, DEPTH);
    bus_w(6'h14, 32'h2);
    begin
      logic [7:0] first;
      first = pat[0];
      pat[0] = 8'h11; pat[1] = 8'h22; pat[2] = 8'h33;
      rx_send(3);
      bus_r(6'h0C, v); check("R9 refused count", v, DEPTH);
      bus_r(6'h14, v); check("R9 refused no flag", v[1], 0);
      bus_r(6'h1C, v); check("R9 refused buffer", v, {24'd0, first});
    end
    rx_send(3);
    bus_r(6'h0C, v); check("R9 accepted after read", v, 3);
    bus_r(6'h1C, v); check("R9 new byte", v, 32'h11);
    bus_w(6'h14, 32'h2);

    // R12 packet end collides with rx-done clear
    fill_pat(5);
    for (int i = 0; i < 4; i++) begin
      rxv = 1'b1; rxd = pat[i]; rxl = 1'b0;
      @(posedge clk); @(negedge clk);
    end
    rxd = pat[4]; rxl = 1'b1;
    addr = 6'h14; wdata = 32'h2; wr = 1'b1;
    @(posedge clk); @(negedge clk);
    rxv = 1'b0; rxl = 1'b0; wr = 1'b0;
    bus_r(6'h14, v); check("R12 event wins", v, ictl_word(0, 1, 0));
    check("R8 irq after collision", irq, 1);
    rx_drain(5);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule